// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and flag stage of a small 8-bit accumulator processor. On each clock where `op_valid` is high, it decodes the presented opcode byte straight from its bit fields. It then runs the selected add, subtract, logical, compare, rotate, complement or carry operation on the accumulator and a second operand. The accumulator result and five status flags are registered in one clock. The second operand arrives already fetched, either as a register value or as an immediate byte. The register-form source field still matters in one case: a source code naming the accumulator makes the block use `acc_in` as the operand.

The stored flags drive a 3-bit condition tester. Branch logic can ask whether a conditional jump, call or return would be taken. Opcodes outside the ALU and flag group leave all state untouched and raise a one-cycle `unhandled` pulse, so surrounding control can dispatch them elsewhere.

Top module: `acc_alu_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted operation, `acc_out` is 0x00, `flags_out` is 0 and `unhandled` is 0. `flags_out` bit order is {4: sign, 3: zero, 2: aux carry, 1: parity, 0: carry}.
- R2: Register-form opcodes `10 ooo sss` and immediate-form opcodes `11 ooo 110` select the operation by `ooo`. For `ooo` = 000 (add) and 001 (add plus stored carry), the result is the 8-bit sum. Carry is the carry out of bit 7 and aux carry is the carry out of bit 3.
- R3: For `ooo` = 010 (subtract) and 011 (subtract with the stored carry as borrow), the result is minuend minus subtrahend minus borrow. Carry is set when subtrahend plus borrow exceeds the minuend. Aux carry is set when the low nibble of the subtrahend plus borrow exceeds the low nibble of the minuend.
- R4: `ooo` = 100 gives AND, with carry cleared and aux carry set. `ooo` = 101 gives XOR and 110 gives OR, each clearing both carry and aux carry.
- R5: `ooo` = 111 (compare) sets every flag exactly as subtract does. `acc_out` becomes `acc_in` unchanged.
- R6: For every operation of R2 to R5, sign equals result bit 7, zero is 1 when the result is 0x00, and parity is 1 when the result has an even number of one bits.
- R7: In register form, source code `sss` = 111 takes `acc_in` as the second operand. Every other source code, and the immediate form, takes `operand`.
- R8: Opcodes 0x07, 0x0F, 0x17 and 0x1F rotate `acc_in` left circular, right circular, left through carry and right through carry respectively. Only the carry flag changes.
- R9: Opcode 0x2F writes the bitwise complement of `acc_in` and leaves all flags unchanged.
- R10: Opcode 0x37 sets carry to 1 and opcode 0x3F inverts carry. The accumulator and the other flags hold.
- R11: Any other opcode presented with `op_valid` high leaves `acc_out` and `flags_out` unchanged. `unhandled` is high for exactly the following cycle.
- R12: With `op_valid` low, `acc_out`, `flags_out` hold and `unhandled` is 0.
- R13: `cond_true` reflects the stored flags in the same cycle. For `cond_code` 000 it is zero==0, for 001 zero==1, for 010 carry==0, for 011 carry==1, for 100 parity==0, for 101 parity==1, for 110 sign==0 and for 111 sign==1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode and operands are valid this cycle |
| opcode | input | 8 | Current opcode byte |
| acc_in | input | 8 | Current accumulator value |
| operand | input | 8 | Fetched register value or immediate byte |
| cond_code | input | 3 | Branch condition to test |
| acc_out | output | 8 | Registered accumulator result |
| flags_out | output | 5 | Stored flags {S, Z, AC, P, CY} |
| cond_true | output | 1 | Selected condition holds on stored flags |
| unhandled | output | 1 | One-cycle pulse for a non-ALU opcode |

## Verification
The flags hold the block's only lasting state. A wrong carry becomes visible at `flags_out` one clock after the operation that set it. It also corrupts the next add-with-carry or subtract-with-borrow result, which the bench issues often. A decode slip that routes an opcode to the wrong class shows on the very next cycle. It appears as an unexpected `unhandled` pulse, a changed accumulator, or a flag that should have held. `cond_true` is compared every cycle against all condition codes, so a corrupted stored flag cannot stay hidden for long.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_ARITH = 3'd1,
        K_ROT   = 3'd2,
        K_CMA   = 3'd3,
        K_STC   = 3'd4,
        K_CMC   = 3'd5
    } kind_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CMP = 3'd7
    } aluop_e;

    typedef enum logic [1:0] {
        ROT_LC = 2'd0,
        ROT_RC = 2'd1,
        ROT_LT = 2'd2,
        ROT_RT = 2'd3
    } rot_e;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [7:0] opcode,
    output kind_e      kind,
    output aluop_e     aluop,
    output rot_e       rot,
    output logic       src_is_acc
);

    logic reg_form;
    logic imm_form;

    always_comb begin
        reg_form   = (opcode[7:6] == 2'b10);
        imm_form   = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b110);
        aluop      = aluop_e'(opcode[5:3]);
        rot        = rot_e'(opcode[4:3]);
        src_is_acc = reg_form && (opcode[2:0] == 3'b111);

        if (reg_form || imm_form) begin
            kind = K_ARITH;
        end else if (opcode[7:5] == 3'b000 && opcode[2:0] == 3'b111) begin
            kind = K_ROT;
        end else if (opcode == 8'h2F) begin
            kind = K_CMA;
        end else if (opcode == 8'h37) begin
            kind = K_STC;
        end else if (opcode == 8'h3F) begin
            kind = K_CMC;
        end else begin
            kind = K_NONE;
        end
    end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  kind_e          kind,
    input  aluop_e         aluop,
    input  rot_e           rot,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  flags_t         flags_in,
    output logic [W-1:0]   result,
    output flags_t         flags_new,
    output logic           write_acc
);

    localparam int NIB = W / 2;

    logic [W:0]     wide;
    logic [NIB:0]   low;
    logic           cin;
    logic [W-1:0]   r;
    flags_t         f;

    always_comb begin
        f         = flags_in;
        r         = a;
        write_acc = 1'b0;
        wide      = '0;
        low       = '0;
        cin       = 1'b0;

        unique case (kind)
            K_ARITH: begin
                write_acc = (aluop != OP_CMP);
                unique case (aluop)
                    OP_ADD, OP_ADC: begin
                        cin  = (aluop == OP_ADC) ? flags_in.cy : 1'b0;
                        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
                        low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
                        r    = wide[W-1:0];
                        f.cy = wide[W];
                        f.ac = low[NIB];
                    end
                    OP_SUB, OP_SBB, OP_CMP: begin
                        cin  = (aluop == OP_SBB) ? flags_in.cy : 1'b0;
                        wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
                        low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
                        r    = wide[W-1:0];
                        f.cy = wide[W];
                        f.ac = low[NIB];
                    end
                    OP_AND: begin
                        r    = a & b;
                        f.cy = 1'b0;
                        f.ac = 1'b1;
                    end
                    OP_XOR: begin
                        r    = a ^ b;
                        f.cy = 1'b0;
                        f.ac = 1'b0;
                    end
                    default: begin
                        r    = a | b;
                        f.cy = 1'b0;
                        f.ac = 1'b0;
                    end
                endcase
                f.s = r[W-1];
                f.z = (r == '0);
                f.p = ~^r;
            end
            K_ROT: begin
                write_acc = 1'b1;
                unique case (rot)
                    ROT_LC: begin
                        r    = {a[W-2:0], a[W-1]};
                        f.cy = a[W-1];
                    end
                    ROT_RC: begin
                        r    = {a[0], a[W-1:1]};
                        f.cy = a[0];
                    end
                    ROT_LT: begin
                        r    = {a[W-2:0], flags_in.cy};
                        f.cy = a[W-1];
                    end
                    default: begin
                        r    = {flags_in.cy, a[W-1:1]};
                        f.cy = a[0];
                    end
                endcase
            end
            K_CMA: begin
                write_acc = 1'b1;
                r         = ~a;
            end
            K_STC: begin
                f.cy = 1'b1;
            end
            K_CMC: begin
                f.cy = ~flags_in.cy;
            end
            default: begin
                write_acc = 1'b0;
            end
        endcase

        result    = r;
        flags_new = f;
    end

endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
    import acc_alu_pkg::*;
(
    input  logic [2:0] cond_code,
    input  flags_t     flags,
    output logic       cond_true
);

    logic picked;

    always_comb begin
        unique case (cond_code[2:1])
            2'b00:   picked = flags.z;
            2'b01:   picked = flags.cy;
            2'b10:   picked = flags.p;
            default: picked = flags.s;
        endcase
        cond_true = (picked == cond_code[0]);
    end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [7:0]   opcode,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] operand,
    input  logic [2:0]   cond_code,
    output logic [W-1:0] acc_out,
    output logic [4:0]   flags_out,
    output logic         cond_true,
    output logic         unhandled
);

    typedef struct packed {
        logic [W-1:0] acc;
        flags_t       flags;
        logic         unh;
    } state_t;

    state_t state_d, state_q;

    kind_e        dec_kind;
    aluop_e       dec_op;
    rot_e         dec_rot;
    logic         dec_src_acc;
    logic [W-1:0] src_b;
    logic [W-1:0] core_res;
    flags_t       core_flags;
    logic         core_wr;

    acc_alu_decode u_decode (
        .opcode     (opcode),
        .kind       (dec_kind),
        .aluop      (dec_op),
        .rot        (dec_rot),
        .src_is_acc (dec_src_acc)
    );

    assign src_b = dec_src_acc ? acc_in : operand;

    acc_alu_core #(.W(W)) u_core (
        .kind      (dec_kind),
        .aluop     (dec_op),
        .rot       (dec_rot),
        .a         (acc_in),
        .b         (src_b),
        .flags_in  (state_q.flags),
        .result    (core_res),
        .flags_new (core_flags),
        .write_acc (core_wr)
    );

    acc_alu_cond u_cond (
        .cond_code (cond_code),
        .flags     (state_q.flags),
        .cond_true (cond_true)
    );

    always_comb begin
        state_d     = state_q;
        state_d.unh = 1'b0;
        if (op_valid) begin
            if (dec_kind == K_NONE) begin
                state_d.unh = 1'b1;
            end else begin
                state_d.flags = core_flags;
                if (core_wr) begin
                    state_d.acc = core_res;
                end else if (dec_kind == K_ARITH) begin
                    state_d.acc = acc_in;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_out   = state_q.acc;
    assign flags_out = state_q.flags;
    assign unhandled = state_q.unh;

    // R11
    unhandled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled |-> (acc_out == $past(acc_out)) && (flags_out == $past(flags_out)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(acc_out) && $stable(flags_out) && !unhandled);

    // R4
    logic_carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && opcode[7:6] == 2'b10 && (opcode[5:3] == 3'b101 || opcode[5:3] == 3'b110)
        |=> !flags_out[0] && !flags_out[2]);

    // R5
    compare_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && opcode[7:6] == 2'b10 && opcode[5:3] == 3'b111 |=> acc_out == $past(acc_in));

    // R8
    rotate_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && opcode == 8'h07 |=> acc_out == {$past(acc_in[W-2:0]), $past(acc_in[W-1])}
                                      && flags_out[0] == $past(acc_in[W-1])
                                      && flags_out[4:1] == $past(flags_out[4:1]));

    // R10
    set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && opcode == 8'h37 |=> flags_out[0] && acc_out == $past(acc_out));

    // R13
    cond_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_code == 3'b001 |-> cond_true == flags_out[3]);

endmodule

// File: tb/acc_alu_unit_tb.sv
module acc_alu_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] operand = 8'h00;
    logic [2:0] cond_code = 3'b000;
    logic [7:0] acc_out;
    logic [4:0] flags_out;
    logic       cond_true;
    logic       unhandled;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference state
    int    m_acc = 0;
    int    m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;
    int    m_unh = 0;
    string m_tag = "R1";

    always #5 clk = ~clk;

    acc_alu_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .opcode    (opcode),
        .acc_in    (acc_in),
        .operand   (operand),
        .cond_code (cond_code),
        .acc_out   (acc_out),
        .flags_out (flags_out),
        .cond_true (cond_true),
        .unhandled (unhandled)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (op=%02h)", tag, act, exp, opcode);
        end
    endtask

    function automatic int exp_cond(input int cc);
        int f;
        case (cc / 2)
            0: f = m_z;
            1: f = m_cy;
            2: f = m_p;
            default: f = m_s;
        endcase
        return (f == (cc % 2)) ? 1 : 0;
    endfunction

    task automatic compare_all();
        int fl;
        fl = (m_s << 4) | (m_z << 3) | (m_ac << 2) | (m_p << 1) | m_cy;
        check({m_tag, " acc"}, acc_out, m_acc);
        check({m_tag, " R6 flags"}, flags_out, fl);
        check({m_tag, " unhandled"}, unhandled, m_unh);
        check("R13 cond", cond_true, exp_cond(cond_code));
    endtask

    task automatic model(input int op, input int a, input int b, input bit v);
        int src, o, r, c;
        m_unh = 0;
        if (!v) begin
            m_tag = "R12";
            return;
        end
        if ((op >> 6) == 2 || ((op >> 6) == 3 && (op & 7) == 6)) begin
            src = ((op >> 6) == 2 && (op & 7) == 7) ? a : b;
            o = (op >> 3) & 7;
            if (o <= 1) begin
                c = (o == 1) ? m_cy : 0;
                r = a + src + c;
                m_cy = (r > 255) ? 1 : 0;
                m_ac = (((a & 15) + (src & 15) + c) > 15) ? 1 : 0;
                r = r & 255;
                m_tag = "R2";
            end else if (o == 2 || o == 3 || o == 7) begin
                c = (o == 3) ? m_cy : 0;
                m_cy = ((src + c) > a) ? 1 : 0;
                m_ac = (((src & 15) + c) > (a & 15)) ? 1 : 0;
                r = (a - src - c) & 255;
                m_tag = (o == 7) ? "R5" : "R3";
            end else begin
                r = (o == 4) ? (a & src) : (o == 5) ? (a ^ src) : (a | src);
                m_cy = 0;
                m_ac = (o == 4) ? 1 : 0;
                m_tag = "R4";
            end
            m_s = (r >> 7) & 1;
            m_z = (r == 0) ? 1 : 0;
            m_p = ($countones(r[7:0]) % 2 == 0) ? 1 : 0;
            m_acc = (o == 7) ? a : r;
            if ((op >> 6) == 2 && (op & 7) == 7) m_tag = {m_tag, " R7"};
        end else if (op == 'h07) begin
            m_acc = ((a << 1) | (a >> 7)) & 255; m_cy = (a >> 7) & 1; m_tag = "R8";
        end else if (op == 'h0F) begin
            m_acc = ((a >> 1) | ((a & 1) << 7)) & 255; m_cy = a & 1; m_tag = "R8";
        end else if (op == 'h17) begin
            m_acc = ((a << 1) | m_cy) & 255; m_cy = (a >> 7) & 1; m_tag = "R8";
        end else if (op == 'h1F) begin
            m_acc = ((a >> 1) | (m_cy << 7)) & 255; m_cy = a & 1; m_tag = "R8";
        end else if (op == 'h2F) begin
            m_acc = (~a) & 255; m_tag = "R9";
        end else if (op == 'h37) begin
            m_cy = 1; m_tag = "R10";
        end else if (op == 'h3F) begin
            m_cy = 1 - m_cy; m_tag = "R10";
        end else begin
            m_unh = 1; m_tag = "R11";
        end
    endtask

    task automatic step(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [2:0] cc, input bit v);
        @(negedge clk);
        compare_all();
        opcode = op; acc_in = a; operand = b; cond_code = cc; op_valid = v;
        model(op, a, b, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 acc", acc_out, 0);
        check("R1 flags", flags_out, 0);
        check("R1 unhandled", unhandled, 0);
        rst_n = 1'b1;
        step(8'h00, 8'h11, 8'h22, 3'd0, 1'b0);
        // R2 add, carry and aux carry boundaries
        step(8'h80, 8'hFF, 8'h01, 3'd1, 1'b1);
        step(8'hC6, 8'h0F, 8'h01, 3'd3, 1'b1);
        step(8'h37, 8'h00, 8'h00, 3'd3, 1'b1);
        step(8'h88, 8'h10, 8'h20, 3'd2, 1'b1);
        // R3 subtract with borrow
        step(8'h90, 8'h10, 8'h11, 3'd3, 1'b1);
        step(8'h98, 8'h05, 8'h05, 3'd1, 1'b1);
        step(8'hD6, 8'h40, 8'h01, 3'd6, 1'b1);
        // R5 compare equal, R7 accumulator source
        step(8'hBF, 8'h5A, 8'h00, 3'd1, 1'b1);
        step(8'h87, 8'h81, 8'h00, 3'd3, 1'b1);
        // R4 logic ops
        step(8'hA0, 8'hF0, 8'h3C, 3'd5, 1'b1);
        step(8'hAF, 8'h77, 8'h00, 3'd1, 1'b1);
        step(8'hF6, 8'h01, 8'h02, 3'd4, 1'b1);
        // R8 rotates, R9 complement, R10 carry ops
        step(8'h37, 8'h00, 8'h00, 3'd3, 1'b1);
        step(8'h17, 8'h40, 8'h00, 3'd3, 1'b1);
        step(8'h1F, 8'h01, 8'h00, 3'd2, 1'b1);
        step(8'h07, 8'h81, 8'h00, 3'd3, 1'b1);
        step(8'h0F, 8'h02, 8'h00, 3'd3, 1'b1);
        step(8'h2F, 8'h5A, 8'h00, 3'd7, 1'b1);
        step(8'h3F, 8'h00, 8'h00, 3'd2, 1'b1);
        // R11 unhandled opcodes
        step(8'h27, 8'hAA, 8'hBB, 3'd0, 1'b1);
        step(8'h76, 8'hAA, 8'hBB, 3'd0, 1'b1);
        step(8'h3E, 8'hAA, 8'hBB, 3'd0, 1'b0);
        // R13 sweep of all conditions
        for (int c = 0; c < 8; c++) step(8'h00, 8'h00, 8'h00, c[2:0], 1'b0);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] op;
            op = 8'($urandom);
            if ($urandom % 4 == 0) op = {2'b10, 6'($urandom)};
            step(op, 8'($urandom), 8'($urandom), 3'($urandom), ($urandom % 8) != 0);
        end
        @(negedge clk);
        compare_all();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule